// File: doc/BRIEF.md
# Serial Receiver with Ninth-Bit Recovery

This block receives asynchronous serial frames on one input line. The far end sends eight data bits, one extra bit and a stop bit, with no parity. The receiver reads the extra bit as though it were an even-parity bit. It then computes the parity bit that the data byte alone would need, and it derives the sender's ninth bit from that value and the parity-check outcome. Each frame is delivered with the byte, the recovered ninth bit, the raw parity-check flag and a framing flag, together with a one-clock valid pulse.

A second mode treats the line as a plain nine-bit link. In that mode the extra bit is passed through without change and the parity flag stays low. In the emulated mode, transmit and receive would share one parity setting, so a `tx_active` input stops a new frame from starting while a local transmission is in progress. Bit timing comes from a 16x oversampling enable supplied from outside. Every bit is judged by a majority vote over three samples taken around the middle of the bit.

Top module: `ninth_bit_uart_rx`

## Requirements
- R1: While reset is active and right after it is released, `out_valid`, `out_data`, `out_ninth`, `out_perr` and `out_ferr` are all 0.
- R2: A frame begins only on a high-to-low transition of the line that is still low at the middle of the start bit, decided by majority vote. A low pulse that is over before mid-bit delivers no frame.
- R3: Each bit is decided by a majority of three samples on consecutive 16x ticks around its middle, so a disturbance that covers only one of those samples does not change the bit.
- R4: The frame order is start bit, eight data bits sent least significant first, the extra bit, then the stop bit. The first data bit on the line becomes `out_data[0]`.
- R5: In emulated mode (`mode_direct`=0), `out_perr` is 1 exactly when the eight data bits and the extra bit together hold an odd number of ones.
- R6: In emulated mode, `out_ninth` equals the even-parity bit computed over `out_data`, XORed with `out_perr`. This reproduces the extra bit that was sent.
- R7: In direct mode (`mode_direct`=1, latched when the frame starts), `out_ninth` is the sampled extra bit and `out_perr` is 0.
- R8: A stop bit sampled low sets `out_ferr` for that frame, and the byte and the ninth bit are still delivered.
- R9: `out_valid` is high for exactly one clock per received frame, at the middle of the stop bit. The output fields keep their values between pulses.
- R10: In emulated mode, a start edge seen while `tx_active` is 1 is ignored and no frame is delivered. In direct mode `tx_active` has no effect. A `tx_active` that rises after a frame has started does not abort that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | Enable pulse at 16 times the bit rate |
| rxd | input | 1 | Serial line, idle high |
| mode_direct | input | 1 | 1 selects direct nine-bit mode, 0 selects parity emulation |
| tx_active | input | 1 | A local transmission is in progress |
| out_valid | output | 1 | One-clock pulse when a frame is delivered |
| out_data | output | 8 | Received byte |
| out_ninth | output | 1 | Recovered ninth bit |
| out_perr | output | 1 | Raw even-parity check flag |
| out_ferr | output | 1 | Stop bit was sampled low |

## Verification
A framing error and a parity mismatch can be reported in the same valid pulse. The bench sends frames whose extra bit makes the parity check fail while the stop bit is held low. For each such frame it checks that both flags are set together and that the byte and the recovered ninth bit are still correct. The blocking input can also rise in the same stretch of time as a start edge. The bench raises `tx_active` before a start edge, and again just after a start has been accepted. The first frame must disappear without a valid pulse, and the second must arrive intact.

// File: rtl/nbr_pkg.sv
package nbr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_EXTRA,
    ST_STOP
  } rx_state_t;

  // two-of-three vote over the samples around mid-bit
  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // even-parity receiver check: set when data parity and the received bit disagree
  function automatic logic parity_mismatch(input logic expected_bit, input logic got_bit);
    return expected_bit ^ got_bit;
  endfunction

  // ninth bit rebuilt from the expected parity and the check outcome
  function automatic logic rebuild_ninth(input logic expected_bit, input logic mismatch);
    return expected_bit ^ mismatch;
  endfunction

endpackage

// File: rtl/nbr_sync.sv
module nbr_sync #(
  parameter int STAGES    = 2,
  parameter bit IDLE_LVL  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic fall
);

  localparam int NS = (STAGES < 2) ? 2 : STAGES;

  logic [NS-1:0] chain;
  logic          prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= {NS{IDLE_LVL}};
      prev  <= IDLE_LVL;
    end else begin
      chain <= {chain[NS-2:0], din};
      prev  <= chain[NS-1];
    end
  end

  assign level = chain[NS-1];
  assign fall  = prev & ~chain[NS-1];

endmodule

// File: rtl/nbr_bit_timer.sv
module nbr_bit_timer
  import nbr_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic tick,
  input  logic rx_level,
  output logic mid_strobe,
  output logic bit_val
);

  localparam int CW  = (OVERSAMPLE > 2) ? $clog2(OVERSAMPLE) : 2;
  localparam int MID = OVERSAMPLE / 2;
  localparam logic [CW-1:0] POS_EARLY = CW'(MID - 1);
  localparam logic [CW-1:0] POS_MID   = CW'(MID);
  localparam logic [CW-1:0] POS_LATE  = CW'(MID + 1);
  localparam logic [CW-1:0] POS_LAST  = CW'(OVERSAMPLE - 1);

  logic [CW-1:0] cnt;
  logic          s_early;
  logic          s_mid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      s_early <= 1'b1;
      s_mid   <= 1'b1;
    end else if (restart) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= (cnt == POS_LAST) ? '0 : cnt + 1'b1;
      if (cnt == POS_EARLY) s_early <= rx_level;
      if (cnt == POS_MID)   s_mid   <= rx_level;
    end
  end

  // third sample is the live level on the late tick
  assign mid_strobe = tick && !restart && (cnt == POS_LATE);
  assign bit_val    = maj3(s_early, s_mid, rx_level);

endmodule

// File: rtl/nbr_shifter.sv
module nbr_shifter #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             shift_en,
  input  logic             bit_in,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= '0;
    else if (clr)      q <= '0;
    else if (shift_en) q <= {bit_in, q[WIDTH-1:1]};
  end

endmodule

// File: rtl/ninth_bit_uart_rx.sv
module ninth_bit_uart_rx
  import nbr_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              rxd,
  input  logic              mode_direct,
  input  logic              tx_active,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_ninth,
  output logic              out_perr,
  output logic              out_ferr
);

  localparam int IW = (DATA_W > 2) ? $clog2(DATA_W) : 2;
  localparam logic [IW-1:0] LAST_IDX = IW'(DATA_W - 1);

  // named internal events, also used by the checker
  logic        rx_level;
  logic        rx_fall;
  logic        mid_strobe;
  logic        bit_val;
  logic        start_blocked;
  logic        accept_start;
  logic        frame_busy;
  logic        frame_direct;
  logic        stop_strobe;

  rx_state_t   state;
  logic [IW-1:0]     idx;
  logic              extra_bit;
  logic [DATA_W-1:0] shreg;

  function automatic logic data_even_bit(input logic [DATA_W-1:0] d);
    return ^d;
  endfunction

  nbr_sync #(.STAGES(SYNC_STAGES), .IDLE_LVL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (rxd),
    .level (rx_level),
    .fall  (rx_fall)
  );

  assign start_blocked = tx_active && !mode_direct;
  assign accept_start  = (state == ST_IDLE) && rx_fall && !start_blocked;
  assign frame_busy    = (state != ST_IDLE);
  assign stop_strobe   = (state == ST_STOP) && mid_strobe;

  nbr_bit_timer #(.OVERSAMPLE(OVERSAMPLE)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (accept_start),
    .tick       (tick16),
    .rx_level   (rx_level),
    .mid_strobe (mid_strobe),
    .bit_val    (bit_val)
  );

  nbr_shifter #(.WIDTH(DATA_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (accept_start),
    .shift_en ((state == ST_DATA) && mid_strobe),
    .bit_in   (bit_val),
    .q        (shreg)
  );

  // frame sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      idx          <= '0;
      extra_bit    <= 1'b0;
      frame_direct <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept_start) begin
            state        <= ST_START;
            frame_direct <= mode_direct;
            idx          <= '0;
          end
        end
        ST_START: begin
          if (mid_strobe) state <= bit_val ? ST_IDLE : ST_DATA;
        end
        ST_DATA: begin
          if (mid_strobe) begin
            if (idx == LAST_IDX) state <= ST_EXTRA;
            else                 idx   <= idx + 1'b1;
          end
        end
        ST_EXTRA: begin
          if (mid_strobe) begin
            extra_bit <= bit_val;
            state     <= ST_STOP;
          end
        end
        ST_STOP: begin
          if (mid_strobe) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // result arithmetic
  logic exp_even;
  logic mismatch;
  logic ninth_n;
  logic perr_n;

  always_comb begin
    exp_even = data_even_bit(shreg);
    mismatch = parity_mismatch(exp_even, extra_bit);
    if (frame_direct) begin
      ninth_n = extra_bit;
      perr_n  = 1'b0;
    end else begin
      ninth_n = rebuild_ninth(exp_even, mismatch);
      perr_n  = mismatch;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_ninth <= 1'b0;
      out_perr  <= 1'b0;
      out_ferr  <= 1'b0;
    end else begin
      out_valid <= stop_strobe;
      if (stop_strobe) begin
        out_data  <= shreg;
        out_ninth <= ninth_n;
        out_perr  <= perr_n;
        out_ferr  <= ~bit_val;
      end
    end
  end

endmodule

// File: rtl/nbr_chk.sv
module nbr_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_active,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              out_ninth,
  input logic              out_perr,
  input logic              out_ferr,
  input logic              frame_direct,
  input logic              frame_busy
);

  // R9
  valid_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R9
  fields_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_data) && $stable(out_ninth) && $stable(out_perr) && $stable(out_ferr)));

  // R7
  direct_no_perr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && frame_direct) |-> !out_perr);

  // R6
  ninth_rebuild_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !frame_direct) |-> (out_ninth == ((^out_data) ^ out_perr)));

  // R10
  blocked_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(frame_busy) && !frame_direct) |-> !$past(tx_active));

endmodule

bind ninth_bit_uart_rx nbr_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tx_active    (tx_active),
  .out_valid    (out_valid),
  .out_data     (out_data),
  .out_ninth    (out_ninth),
  .out_perr     (out_perr),
  .out_ferr     (out_ferr),
  .frame_direct (frame_direct),
  .frame_busy   (frame_busy)
);

// File: tb/tb_ninth_bit_uart_rx.sv
module tb_ninth_bit_uart_rx;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       rxd = 1'b1;
  logic       mode_direct = 1'b0;
  logic       tx_active = 1'b0;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_ninth, out_perr, out_ferr;

  int checks = 0;
  int failures = 0;
  int vcount = 0;
  int cyc = 0;
  int tdiv = 0;
  bit done = 0;
  bit prev_valid = 0;
  logic [11:0] held;
  // entry: {direct, ferr, perr, ninth, data}
  logic [11:0] exp_q[$];

  ninth_bit_uart_rx dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
    .mode_direct(mode_direct), .tx_active(tx_active),
    .out_valid(out_valid), .out_data(out_data), .out_ninth(out_ninth),
    .out_perr(out_perr), .out_ferr(out_ferr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    tdiv   <= (tdiv == TICK_DIV-1) ? 0 : tdiv + 1;
    tick16 <= (tdiv == TICK_DIV-1);
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      check(1'b0, "R9", "watchdog expired", cyc, WATCHDOG);
      finish_run();
    end
  end

  // reference comparison on every clock
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        vcount++;
        check(!prev_valid, "R9", "valid longer than one clock", 1, 0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R9", "unexpected valid", 1, 0);
        end else begin
          logic [11:0] e;
          e = exp_q.pop_front();
          check(out_data == e[7:0], "R4", "data", out_data, e[7:0]);
          check(out_ninth == e[8], e[11] ? "R7" : "R6", "ninth", out_ninth, e[8]);
          check(out_perr == e[9], e[11] ? "R7" : "R5", "perr", out_perr, e[9]);
          check(out_ferr == e[10], "R8", "ferr", out_ferr, e[10]);
        end
      end else begin
        check({out_ferr, out_perr, out_ninth, out_data} == held[10:0], "R9",
              "fields changed without valid", {out_ferr, out_perr, out_ninth, out_data}, held[10:0]);
      end
      held <= {1'b0, out_ferr, out_perr, out_ninth, out_data};
      prev_valid <= out_valid;
    end
  end

  task automatic wait_tick();
    @(posedge clk);
    while (tick16 !== 1'b1) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic hold_line(input logic v, input int n);
    rxd = v;
    for (int i = 0; i < n; i++) wait_tick();
  endtask

  task automatic send_frame(input logic [7:0] d, input logic ex, input logic stp,
                            input logic [10:0] glitch, input int expect_n, input string tag);
    logic [10:0] bits;
    int v0;
    logic pe;
    bits = {stp, ex, d, 1'b0};
    v0 = vcount;
    if (expect_n == 1) begin
      pe = mode_direct ? 1'b0 : ((^d) ^ ex);
      exp_q.push_back({mode_direct, ~stp, pe, ex, d});
    end
    for (int b = 0; b < 11; b++) begin
      for (int p = 0; p < 16; p++) begin
        rxd = (glitch[b] && p == 8) ? ~bits[b] : bits[b];
        wait_tick();
      end
    end
    hold_line(1'b1, stp ? 4 : 16);
    check((vcount - v0) == expect_n, tag, "frames delivered", vcount - v0, expect_n);
  endtask

  initial begin
    held = '0;
    repeat (5) @(negedge clk);
    // R1 reset state
    check({out_valid, out_data, out_ninth, out_perr, out_ferr} == '0, "R1", "reset outputs",
          {out_valid, out_data, out_ninth, out_perr, out_ferr}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({out_valid, out_data, out_ninth, out_perr, out_ferr} == '0, "R1", "after release",
          {out_valid, out_data, out_ninth, out_perr, out_ferr}, 0);
    hold_line(1'b1, 20);

    // R4 R5 R6 emulated mode, several patterns
    send_frame(8'hA5, 1'b0, 1'b1, '0, 1, "R4");
    send_frame(8'h3C, 1'b1, 1'b1, '0, 1, "R5");
    send_frame(8'h01, 1'b1, 1'b1, '0, 1, "R6");
    send_frame(8'hFE, 1'b0, 1'b1, '0, 1, "R6");

    // R7 direct mode
    mode_direct = 1'b1;
    send_frame(8'h7E, 1'b1, 1'b1, '0, 1, "R7");
    send_frame(8'h80, 1'b0, 1'b1, '0, 1, "R7");
    // R10 tx_active ignored in direct mode
    tx_active = 1'b1;
    send_frame(8'h5A, 1'b1, 1'b1, '0, 1, "R10");
    tx_active = 1'b0;
    mode_direct = 1'b0;

    // R8 low stop with parity mismatch in the same frame
    send_frame(8'h55, 1'b1, 1'b0, '0, 1, "R8");
    send_frame(8'hC3, 1'b1, 1'b0, '0, 1, "R8");

    // R3 single-sample disturbance on start, data bits and extra bit
    send_frame(8'h96, 1'b1, 1'b1, 11'b010_0110_1001, 1, "R3");

    // R2 short low pulse is not a start
    begin
      int v0;
      v0 = vcount;
      hold_line(1'b0, 4);
      hold_line(1'b1, 40);
      check(vcount == v0, "R2", "false start produced frame", vcount - v0, 0);
    end

    // R10 blocked start in emulated mode
    tx_active = 1'b1;
    send_frame(8'h44, 1'b0, 1'b1, '0, 0, "R10");
    tx_active = 1'b0;
    hold_line(1'b1, 4);

    // R10 tx_active rises after start accepted
    fork
      send_frame(8'h2B, 1'b1, 1'b1, '0, 1, "R10");
      begin
        for (int i = 0; i < 40; i++) wait_tick();
        tx_active = 1'b1;
      end
    join
    tx_active = 1'b0;

    // R9 back-to-back frames with a short idle
    send_frame(8'hFF, 1'b1, 1'b1, '0, 1, "R9");
    send_frame(8'h00, 1'b0, 1'b1, '0, 1, "R9");

    check(exp_q.size() == 0, "R9", "frames outstanding", exp_q.size(), 0);
    hold_line(1'b1, 8);
    finish_run();
  end

endmodule